// File: doc/BRIEF.md
# Transmit Queue Completion Sequencer

This block walks a transmit engine through a queue of packet numbers that software has placed in it, one packet at a time. For each packet it issues a one-cycle launch strobe with the packet number, then waits for the transmit datapath to return a single result strobe marked good or bad. When a good result leaves nothing waiting, it raises the queue-empty interrupt. When a bad result arrives, it raises the failure interrupt, clears its own enable bit, stops launching and keeps the failing packet number readable.

Software recovers by writing a packet number to the restart register and setting the enable bit again. That packet is launched first, and the remaining queue entries follow in order. Both interrupt bits are sticky until software acknowledges them.

The controller has three states. **IDLE** waits for work. **BUSY** holds one packet in flight. **HALT** is entered after a failure. The transitions are:

- **LAUNCH** (IDLE→BUSY): enabled, and either a restart is pending or the queue is non-empty.
- **DONE** (BUSY→IDLE): good result.
- **ABORT** (BUSY→HALT): bad result.
- **RESUME** (HALT→IDLE): the enable bit is set again.

Top module: `txq_seq`

## Requirements
- R1: After reset, tx_en, irq_status, launch, ovf and q_level are all 0.
- R2: Queued packet numbers are launched in push order. Each launch is a single-cycle pulse with the number on launch_pnum. A launch occurs only when tx_en was 1 in the previous cycle.
- R3: The queue holds 8 entries. A push while q_level is 8 is ignored, even if an entry leaves in that same cycle, and it sets ovf, which stays 1 until reset.
- R4: At most one packet is in flight. After a good result is sampled on a rising edge, the next launch appears at the following rising edge, never at the same one.
- R5: A good result with the queue empty and no restart pending sets irq_status[0] (queue-empty).
- R6: A bad result (res_valid=1, res_ok=0) sets irq_status[1] (failure) and clears tx_en. No further launch occurs while tx_en is 0, even if the queue holds entries.
- R7: After a bad result, fail_pnum equals the number of the failed packet and holds it until the next failure.
- R8: A bad result never sets irq_status[0], even when it ends the last queued packet.
- R9: Writing pnum_wr with a number and then setting tx_en makes that number the next launch. The queued entries follow it in order.
- R10: ack_wr with ack_mask bit k set clears irq_status[k] (bit 0 queue-empty, bit 1 failure). A setting event in the same cycle wins over the clear.
- R11: en_wr loads tx_en from en_wr_val. A bad result in the same cycle wins, leaving tx_en at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Enqueue strobe |
| push_pnum | input | 6 | Packet number to enqueue |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wr_val | input | 1 | Value written to the enable bit |
| pnum_wr | input | 1 | Write strobe for the restart packet number |
| pnum_wr_val | input | 6 | Restart packet number |
| ack_wr | input | 1 | Interrupt acknowledge strobe |
| ack_mask | input | 2 | Bits to clear (0 empty, 1 failure) |
| res_valid | input | 1 | Result strobe from the datapath |
| res_ok | input | 1 | Result is good when 1 |
| launch | output | 1 | One-cycle packet start strobe |
| launch_pnum | output | 6 | Number of the packet in flight |
| tx_en | output | 1 | Transmit enable bit |
| irq_status | output | 2 | Sticky interrupt bits |
| fail_pnum | output | 6 | Number of the last failed packet |
| ovf | output | 1 | Sticky queue overflow flag |
| q_level | output | 4 | Entries waiting in the queue |

## Verification
The bench goes after the failure stop: a design that only raised the interrupt would keep launching the two entries still queued. It also checks that a design which tied the queue-empty interrupt to the queue draining would raise it on the failed last packet. The restart is checked to launch the written number before the queued tail, and the result-to-launch spacing is checked so that a back-to-back launch is caught. Further checks cover a push into a full queue, which must not displace or add an entry, and an acknowledge that coincides with a new event, which must not erase it. A failure that coincides with an enable write must still leave the block stopped.

// File: rtl/txq_pkg.sv
package txq_pkg;
    localparam int PNUM_W  = 6;
    localparam int Q_DEPTH = 8;
    localparam int N_IRQ   = 2;
    localparam int IRQ_EMPTY = 0;
    localparam int IRQ_FAIL  = 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUSY,
        ST_HALT
    } seq_state_e;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
    parameter int W     = 6,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end
endmodule

// File: rtl/txq_irq.sv
module txq_irq #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] status
);
    for (genvar k = 0; k < N; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)      status[k] <= 1'b0;
            else if (set[k]) status[k] <= 1'b1;
            else if (clr[k]) status[k] <= 1'b0;
        end
    end
endmodule

// File: rtl/txq_seq.sv
module txq_seq
    import txq_pkg::*;
#(
    parameter int PW    = PNUM_W,
    parameter int DEPTH = Q_DEPTH,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [PW-1:0]     push_pnum,
    input  logic              en_wr,
    input  logic              en_wr_val,
    input  logic              pnum_wr,
    input  logic [PW-1:0]     pnum_wr_val,
    input  logic              ack_wr,
    input  logic [N_IRQ-1:0]  ack_mask,
    input  logic              res_valid,
    input  logic              res_ok,
    output logic              launch,
    output logic [PW-1:0]     launch_pnum,
    output logic              tx_en,
    output logic [N_IRQ-1:0]  irq_status,
    output logic [PW-1:0]     fail_pnum,
    output logic              ovf,
    output logic [CW-1:0]     q_level
);
    seq_state_e state, state_nxt;

    logic          q_full, q_empty;
    logic [PW-1:0] q_head;
    logic          pop, do_launch, ev_empty, ev_fail;
    logic          rst_pend;
    logic [PW-1:0] rst_pnum;
    logic [N_IRQ-1:0] irq_set, irq_clr;

    txq_fifo #(.W(PW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_valid),
        .din   (push_pnum),
        .pop   (pop),
        .dout  (q_head),
        .count (q_level),
        .full  (q_full),
        .empty (q_empty)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Next state and control strobes
    always_comb begin
        state_nxt = state;
        do_launch = 1'b0;
        pop       = 1'b0;
        ev_empty  = 1'b0;
        ev_fail   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (tx_en && (rst_pend || !q_empty)) begin
                    do_launch = 1'b1;
                    pop       = !rst_pend;
                    state_nxt = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (res_valid) begin
                    if (res_ok) begin
                        ev_empty  = q_empty && !rst_pend;
                        state_nxt = ST_IDLE;
                    end else begin
                        ev_fail   = 1'b1;
                        state_nxt = ST_HALT;
                    end
                end
            end
            ST_HALT: begin
                if (tx_en) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Registered outputs and software-visible registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            launch      <= 1'b0;
            launch_pnum <= '0;
            fail_pnum   <= '0;
            tx_en       <= 1'b0;
            ovf         <= 1'b0;
            rst_pend    <= 1'b0;
            rst_pnum    <= '0;
        end else begin
            launch <= do_launch;
            if (do_launch) launch_pnum <= rst_pend ? rst_pnum : q_head;
            if (ev_fail)   fail_pnum   <= launch_pnum;
            if (ev_fail)    tx_en <= 1'b0;
            else if (en_wr) tx_en <= en_wr_val;
            if (push_valid && q_full) ovf <= 1'b1;
            if (pnum_wr) begin
                rst_pend <= 1'b1;
                rst_pnum <= pnum_wr_val;
            end else if (do_launch) begin
                rst_pend <= 1'b0;
            end
        end
    end

    always_comb begin
        irq_set            = '0;
        irq_set[IRQ_EMPTY] = ev_empty;
        irq_set[IRQ_FAIL]  = ev_fail;
        irq_clr            = ack_wr ? ack_mask : '0;
    end

    txq_irq #(.N(N_IRQ)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (irq_set),
        .clr    (irq_clr),
        .status (irq_status)
    );
endmodule

// File: rtl/txq_seq_chk.sv
module txq_seq_chk #(
    parameter int PW    = 6,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_valid,
    input logic          ack_wr,
    input logic [1:0]    ack_mask,
    input logic          res_valid,
    input logic          res_ok,
    input logic          launch,
    input logic [PW-1:0] launch_pnum,
    input logic          tx_en,
    input logic [1:0]    irq_status,
    input logic [PW-1:0] fail_pnum,
    input logic          ovf,
    input logic [CW-1:0] q_level
);
    logic busy_q;
    logic busy_now;
    logic bad_res;

    assign busy_now = busy_q || launch;
    assign bad_res  = res_valid && !res_ok && busy_now;

    always_ff @(posedge clk) begin
        if (!rst_n)                    busy_q <= 1'b0;
        else if (res_valid && busy_now) busy_q <= 1'b0;
        else if (launch)               busy_q <= 1'b1;
    end

    a_r2_launch_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> $past(tx_en));

    a_r3_full_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && q_level == CW'(DEPTH)) |=> (ovf && q_level <= CW'(DEPTH)));

    a_r4_single_inflight: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !busy_q);

    a_r6_fail_stops: assert property (@(posedge clk) disable iff (!rst_n)
        bad_res |=> (!tx_en && irq_status[1]));

    a_r7_fail_pnum: assert property (@(posedge clk) disable iff (!rst_n)
        bad_res |=> (fail_pnum == $past(launch_pnum)));

    a_r8_no_empty_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_res && !irq_status[0]) |=> !irq_status[0]);

    a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && ack_mask[1] && !bad_res) |=> !irq_status[1]);
endmodule

bind txq_seq txq_seq_chk #(.PW(PW), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/test_txq_seq.sv
module test_txq_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_valid = 1'b0;
    logic [5:0] push_pnum = '0;
    logic       en_wr = 1'b0, en_wr_val = 1'b0;
    logic       pnum_wr = 1'b0;
    logic [5:0] pnum_wr_val = '0;
    logic       ack_wr = 1'b0;
    logic [1:0] ack_mask = '0;
    logic       res_valid = 1'b0, res_ok = 1'b0;
    logic       launch, tx_en, ovf;
    logic [5:0] launch_pnum, fail_pnum;
    logic [1:0] irq_status;
    logic [3:0] q_level;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    txq_seq i_txq_seq (.*);

    // rows: {packet number expected at launch, result to return}
    localparam logic [6:0] VEC [0:5] = '{
        {6'd5, 1'b1}, {6'd9, 1'b1}, {6'd12, 1'b0},
        {6'd12, 1'b1}, {6'd20, 1'b1}, {6'd33, 1'b1}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(logic [5:0] v);
        push_valid = 1'b1; push_pnum = v;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic wr_en(logic v);
        en_wr = 1'b1; en_wr_val = v;
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    task automatic ack(logic [1:0] m);
        ack_wr = 1'b1; ack_mask = m;
        @(negedge clk);
        ack_wr = 1'b0;
    endtask

    task automatic result(logic ok);
        res_valid = 1'b1; res_ok = ok;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic wait_launch(logic [5:0] exp, string req);
        int n = 0;
        while (!launch && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk(req, launch, 1);
        chk(req, launch_pnum, exp);
        @(negedge clk);
        chk({req, " pulse"}, launch, 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 tx_en", tx_en, 0);
        chk("R1 irq", irq_status, 0);
        chk("R1 launch", launch, 0);
        chk("R1 ovf", ovf, 0);
        chk("R1 q_level", q_level, 0);

        push(6'd5); push(6'd9); push(6'd12); push(6'd20); push(6'd33);
        chk("R2 level", q_level, 5);
        repeat (3) @(negedge clk);
        chk("R6 no launch while disabled", launch, 0);
        wr_en(1'b1);
        chk("R11 en write", tx_en, 1);

        for (int i = 0; i < 6; i++) begin
            wait_launch(VEC[i][6:1], "R2 order");
            result(VEC[i][0]);
            if (!VEC[i][0]) begin
                chk("R6 irq fail", irq_status[1], 1);
                chk("R8 no empty irq", irq_status[0], 0);
                chk("R6 en cleared", tx_en, 0);
                chk("R7 fail pnum", fail_pnum, VEC[i][6:1]);
                for (int k = 0; k < 5; k++) begin
                    chk("R6 stopped", launch, 0);
                    @(negedge clk);
                end
                chk("R6 queue kept", q_level, 2);
                ack(2'b11);
                chk("R10 ack clear", irq_status, 0);
                pnum_wr = 1'b1; pnum_wr_val = VEC[i][6:1];
                @(negedge clk);
                pnum_wr = 1'b0;
                wr_en(1'b1);
                chk("R9 restart first", launch_pnum, VEC[i][6:1]);
            end else if (i != 5) begin
                chk("R4 no same-edge launch", launch, 0);
                chk("R5 empty not early", irq_status[0], 0);
                @(negedge clk);
                chk("R4 next launch", launch, 1);
            end
        end
        chk("R5 empty irq", irq_status, 2'b01);
        chk("R7 fail pnum held", fail_pnum, 12);

        // overflow
        wr_en(1'b0);
        ack(2'b01);
        chk("R10 ack empty", irq_status[0], 0);
        for (int i = 0; i < 8; i++) push(6'(40 + i));
        chk("R3 full level", q_level, 8);
        chk("R3 no ovf yet", ovf, 0);
        push(6'd63);
        chk("R3 ignored", q_level, 8);
        chk("R3 ovf", ovf, 1);
        wr_en(1'b1);
        for (int i = 0; i < 8; i++) begin
            wait_launch(6'(40 + i), "R3 drain order");
            result(1'b1);
        end
        chk("R5 empty after drain", irq_status[0], 1);
        repeat (4) @(negedge clk);
        chk("R3 extra not launched", launch, 0);
        chk("R3 ovf sticky", ovf, 1);

        // ack collides with new empty event
        push(6'd7);
        wait_launch(6'd7, "R2 single");
        res_valid = 1'b1; res_ok = 1'b1; ack_wr = 1'b1; ack_mask = 2'b01;
        @(negedge clk);
        res_valid = 1'b0; ack_wr = 1'b0;
        chk("R10 event wins", irq_status[0], 1);
        ack(2'b01);
        chk("R10 ack alone", irq_status[0], 0);

        // failure collides with enable write
        push(6'd3);
        wait_launch(6'd3, "R2 single");
        res_valid = 1'b1; res_ok = 1'b0; en_wr = 1'b1; en_wr_val = 1'b1;
        @(negedge clk);
        res_valid = 1'b0; en_wr = 1'b0;
        chk("R11 fail wins", tx_en, 0);
        chk("R7 fail pnum", fail_pnum, 3);
        chk("R8 no empty", irq_status[0], 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule